// File: doc/BRIEF.md
# Multi-Point Trace Capture Memory

This block is an on-chip debug recorder. In every clock cycle it may take one 64-bit data word from one of four probe points, for example the push and pop sides of two FIFOs, and write it into a 2048-entry circular memory. Each stored entry is 72 bits wide. It holds the data word, the number of the probe the word came from, and a six-bit count of the clock cycles since the previous stored entry.

Software controls the recorder through a small register port. A control register arms the recorder, disarms it, and clears it with an explicit command. An index register selects one entry. A data window returns the selected entry. A status register reports the write pointer and three flags: armed, wrapped and frozen. A further register reports how many samples were lost.

An error-detect input, for example a checksum failure, freezes capture. The entries recorded up to and including the faulting cycle are then kept until software reads them out. Two resets exist, and they do different things:
- The power-on reset `rst_n` clears all control state.
- The host reset `host_rst` only disarms the recorder. Stored entries, the pointer, the flags and the loss count survive it.

Top module: `trace_recorder`

## Requirements
- R1: A stored entry reads back through the data window as follows: bits 71:8 hold the probe data word, bits 7:6 hold the probe number (0 to 3), and bits 5:0 hold the cycle delta.
- R2: At most one sample is stored per cycle. When several probes are valid in the same cycle, the lowest-numbered valid probe is the one stored.
- R3: In every capturing cycle, the loss counter grows by the number of valid probes that were not stored. The counter saturates at its maximum value and reads at register address 3 in bits 15:0.
- R4: The cycle-delta field counts the capture-enabled clock edges since the previous stored sample. For the first sample after a clear, it counts the edges since the clear. The field saturates at 63, so back-to-back samples give 1.
- R5: The write pointer advances by one for each stored sample and wraps from 2047 to 0. Wrapping sets a sticky wrapped flag, and only a clear resets that flag.
- R6: Freeze is accepted while capture is enabled. A sample present in the same cycle as the freeze is still stored. From the next cycle on, nothing is stored and no losses are counted, and the frozen flag stays set until a clear.
- R7: Host reset clears only the armed flag. The stored entries, the pointer, the wrapped flag, the frozen flag and the loss count are unchanged. While the recorder is disarmed, probe activity has no effect.
- R8: A write to address 0 with bit 2 set is the clear command. It zeroes the pointer, the wrapped flag, the frozen flag and the loss count, and it restarts the delta count. In the same write, bit 0 arms the recorder and bit 1 disarms it.
- R9: The read port returns the register that `reg_addr` selected at the previous clock edge.
  - Address 0 is status: bits 15:0 hold the pointer, bit 16 is armed, bit 17 is wrapped and bit 18 is frozen.
  - Address 1 is the index register.
  - Address 2 is the data window. It shows the entry at the index that was held before that edge, so data appears two edges after the index write.
- R10: After power-on reset, the recorder is disarmed and not frozen. The status register and the loss count read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| host_rst | input | 1 | Synchronous host reset; disarms only |
| probe_valid | input | 4 | One valid bit per probe point |
| probe_data | input | 256 | Four 64-bit probe words; probe k uses bits 64k+63:64k |
| freeze_in | input | 1 | Error detect; freezes capture |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 index, 2 data window, 3 losses |
| reg_wdata | input | 11 | Write data: control bits 2:0 or index value |
| reg_rdata | output | 72 | Read data of the register selected one edge earlier |

## Verification
The hardest state to reach from the ports is a wrapped buffer, because it needs more than 2048 stored samples. The stimulus drives 2051 back-to-back samples that rotate across the probes. It then checks the wrapped flag, the pointer value 3, and every slot, where the first three slots must hold the newest samples. Two other narrow corners are also driven. One is a freeze raised in the same cycle as a sample, followed by all-probes-valid cycles that must leave both the memory and the loss counter untouched. The other is an idle gap of 100 cycles, which must saturate the delta field at 63.

// File: rtl/trace_pkg.sv
package trace_pkg;

  // width of the cycle-delta field of each entry
  localparam int TS_W = 6;

  // control register bit positions
  localparam int CTL_ARM  = 0;
  localparam int CTL_STOP = 1;
  localparam int CTL_CLR  = 2;

  // register port addresses
  typedef enum logic [1:0] {
    RA_STAT   = 2'd0,
    RA_INDEX  = 2'd1,
    RA_WINDOW = 2'd2,
    RA_DROPS  = 2'd3
  } reg_sel_e;

  // saturating advance of the cycle-delta counter
  function automatic logic [TS_W-1:0] ts_advance(input logic [TS_W-1:0] cur);
    return (&cur) ? cur : cur + TS_W'(1);
  endfunction

endpackage

// File: rtl/trace_arbiter.sv
module trace_arbiter #(
  parameter  int NPROBE = 4,
  parameter  int DATA_W = 64,
  localparam int ID_W   = $clog2(NPROBE),
  localparam int CNT_W  = $clog2(NPROBE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [NPROBE-1:0]        valid,
  input  logic [NPROBE*DATA_W-1:0] data,
  output logic                     hit,
  output logic [NPROBE-1:0]        grant,
  output logic [ID_W-1:0]          win_id,
  output logic [DATA_W-1:0]        win_data,
  output logic [CNT_W-1:0]         n_lost
);

  int n_valid;

  // fixed priority: lowest index wins
  always_comb begin
    win_id = '0;
    hit    = 1'b0;
    grant  = '0;
    for (int i = NPROBE - 1; i >= 0; i--) begin
      if (valid[i]) win_id = ID_W'(i);
    end
    if (en && (|valid)) begin
      hit           = 1'b1;
      grant[win_id] = 1'b1;
    end
  end

  assign win_data = data[win_id*DATA_W +: DATA_W];

  always_comb begin
    n_valid = 0;
    for (int i = 0; i < NPROBE; i++) n_valid += int'(valid[i]);
    n_lost = (en && n_valid > 0) ? CNT_W'(n_valid - 1) : '0;
  end

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((valid & (grant - NPROBE'(1))) == '0));

  p_lost_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((int'(n_lost) + 1) == $countones(valid)));

endmodule

// File: rtl/trace_delta.sv
module trace_delta
  import trace_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic            took,
  output logic [TS_W-1:0] delta
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            delta <= TS_W'(1);
    else if (clr || took)  delta <= TS_W'(1);
    else if (run)          delta <= ts_advance(delta);
  end

  p_delta_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    delta != '0);

  p_delta_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !took && (&delta)) |=> (&delta));

endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter  int DEPTH   = 2048,
  parameter  int ENTRY_W = 72,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [ENTRY_W-1:0] wentry,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic               wrapped
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic               at_last;

  assign at_last = (wr_ptr == PTR_W'(DEPTH - 1));

  // storage array has no reset: contents survive every reset
  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wentry;
    rd_entry <= mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      wrapped <= 1'b0;
    end else if (we) begin
      wr_ptr <= at_last ? '0 : wr_ptr + PTR_W'(1);
      if (at_last) wrapped <= 1'b1;
    end
  end

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (int'(wr_ptr) == ((int'($past(wr_ptr)) + 1) % DEPTH)));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(wr_ptr));

  p_wrap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !clr) |=> wrapped);

  p_clear_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_ptr == '0 && !wrapped));

endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
  import trace_pkg::*;
#(
  parameter  int NPROBE  = 4,
  parameter  int DATA_W  = 64,
  parameter  int DEPTH   = 2048,
  parameter  int DROP_W  = 16,
  localparam int ID_W    = $clog2(NPROBE),
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(NPROBE + 1),
  localparam int ENTRY_W = DATA_W + ID_W + TS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_rst,
  input  logic [NPROBE-1:0]        probe_valid,
  input  logic [NPROBE*DATA_W-1:0] probe_data,
  input  logic                     freeze_in,
  input  logic                     reg_we,
  input  logic [1:0]               reg_addr,
  input  logic [PTR_W-1:0]         reg_wdata,
  output logic [ENTRY_W-1:0]       reg_rdata
);

  // named internal events
  logic              ctl_wr, clr, capt_en, wr_en;
  logic              armed_q, frozen_q;
  logic [PTR_W-1:0]  idx_q, wr_ptr;
  logic              wrapped;
  logic [DROP_W-1:0] drops_q;
  logic [1:0]        addr_q;
  logic [NPROBE-1:0] grant;
  logic [ID_W-1:0]   win_id;
  logic [DATA_W-1:0] win_data;
  logic [CNT_W-1:0]  n_lost;
  logic [TS_W-1:0]   delta;
  logic [ENTRY_W-1:0] rd_entry;
  logic [DROP_W:0]   drop_sum;

  assign ctl_wr  = reg_we && (reg_addr == RA_STAT);
  assign clr     = ctl_wr && reg_wdata[CTL_CLR];
  assign capt_en = armed_q && !frozen_q && !host_rst && !clr;

  trace_arbiter #(.NPROBE(NPROBE), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(capt_en),
    .valid(probe_valid), .data(probe_data),
    .hit(wr_en), .grant(grant), .win_id(win_id),
    .win_data(win_data), .n_lost(n_lost)
  );

  trace_delta u_delta (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .run(capt_en), .took(wr_en), .delta(delta)
  );

  trace_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .we(wr_en),
    .wentry({win_data, win_id, delta}),
    .rd_idx(idx_q), .rd_entry(rd_entry),
    .wr_ptr(wr_ptr), .wrapped(wrapped)
  );

  // arm / disarm; host reset only drops the armed flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (host_rst) armed_q <= 1'b0;
    else if (ctl_wr) begin
      if (reg_wdata[CTL_ARM])       armed_q <= 1'b1;
      else if (reg_wdata[CTL_STOP]) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     frozen_q <= 1'b0;
    else if (clr)                   frozen_q <= 1'b0;
    else if (capt_en && freeze_in)  frozen_q <= 1'b1;
  end

  assign drop_sum = {1'b0, drops_q} + (DROP_W + 1)'(n_lost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drops_q <= '0;
    else if (clr)     drops_q <= '0;
    else if (capt_en) drops_q <= drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      addr_q <= reg_addr;
      if (reg_we && reg_addr == RA_INDEX) idx_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(addr_q))
      RA_STAT:   reg_rdata = ENTRY_W'({frozen_q, wrapped, armed_q, 16'(wr_ptr)});
      RA_INDEX:  reg_rdata = ENTRY_W'(idx_q);
      RA_WINDOW: reg_rdata = rd_entry;
      default:   reg_rdata = ENTRY_W'(drops_q);
    endcase
  end

  p_frozen_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> !wr_en);

  p_freeze_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capt_en && freeze_in) |=> frozen_q);

  p_host_rst_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rst && !clr) |=> (!armed_q && $stable(wr_ptr) && $stable(drops_q)));

  p_disarmed_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !wr_en);

  p_drop_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (drops_q >= $past(drops_q)));

  p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!frozen_q && drops_q == '0));

endmodule

// File: tb/trace_recorder_tb.sv
module trace_recorder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP    = 4;
  localparam int DW    = 64;
  localparam int DEPTH = 2048;
  localparam int EW    = 72;

  typedef struct {
    int          slot;
    logic [63:0] data;
    logic [1:0]  id;
    logic [5:0]  ts;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_rst = 1'b0;
  logic [NP-1:0]   probe_valid = '0;
  logic [NP*DW-1:0] probe_data = '0;
  logic            freeze_in = 1'b0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic [10:0]     reg_wdata = '0;
  logic [EW-1:0]   reg_rdata;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;

  // reference model state
  bit armed_m = 0, frozen_m = 0, wrapped_m = 0;
  int ptr_m = 0, drops_m = 0, last_edge = 0;
  exp_t exp_q[$];

  trace_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
    .probe_valid(probe_valid), .probe_data(probe_data),
    .freeze_in(freeze_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mkdata(int n, int p);
    return {16'(32'hD000 + p), 16'(n), 32'(n * 7 + p)};
  endfunction

  task automatic check(bit ok, string req, logic [EW-1:0] act, logic [EW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int v);
    int e;
    e = cyc + 1;
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 11'(v);
    if (a == 0) begin
      if (v[2]) begin
        ptr_m = 0; wrapped_m = 0; frozen_m = 0; drops_m = 0; last_edge = e;
      end
      if (v[0]) armed_m = 1;
      else if (v[1]) armed_m = 0;
    end
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [EW-1:0] v);
    reg_addr = 2'(a);
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  // driver: one cycle of probe activity, expected entries pushed to queue
  task automatic step(logic [3:0] mask, bit frz, int n);
    int e, lp, cnt;
    exp_t it;
    e = cyc + 1;
    probe_valid = mask;
    freeze_in   = frz;
    for (int p = 0; p < NP; p++) probe_data[p*DW +: DW] = mkdata(n, p);
    if (armed_m && !frozen_m) begin
      if (mask != 0) begin
        lp = 0; cnt = 0;
        for (int p = NP - 1; p >= 0; p--) if (mask[p]) begin lp = p; cnt++; end
        it.slot = ptr_m;
        it.data = mkdata(n, lp);
        it.id   = 2'(lp);
        it.ts   = 6'((e - last_edge) > 63 ? 63 : (e - last_edge));
        exp_q.push_back(it);
        last_edge = e;
        ptr_m = (ptr_m + 1) % DEPTH;
        if (ptr_m == 0) wrapped_m = 1;
        drops_m += cnt - 1;
      end
      if (frz) frozen_m = 1;
    end
    @(posedge clk); @(negedge clk);
    probe_valid = '0;
    freeze_in   = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(4'b0000, 1'b0, 0);
  endtask

  task automatic host_reset();
    host_rst = 1'b1;
    armed_m  = 0;
    @(posedge clk); @(negedge clk);
    host_rst = 1'b0;
  endtask

  task automatic check_status(string req);
    logic [EW-1:0] v, es;
    es = EW'({frozen_m, wrapped_m, armed_m, 16'(ptr_m)});
    rd_reg(0, v);
    check(v == es, {req, " status"}, v, es);
    rd_reg(3, v);
    check(v == EW'(drops_m), {req, " losses"}, v, EW'(drops_m));
  endtask

  // monitor: pop expected items, read each touched slot, compare
  task automatic monitor_drain(string req);
    exp_t img[int];
    exp_t it;
    logic [EW-1:0] v, ev;
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      img[it.slot] = it;
    end
    foreach (img[s]) begin
      wr_reg(1, s);
      rd_reg(2, v);
      ev = {img[s].data, img[s].id, img[s].ts};
      check(v === ev, $sformatf("%s slot %0d", req, s), v, ev);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic [EW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: power-on state
    check_status("R10");

    // segment 1: priority, losses, deltas
    wr_reg(0, 5);
    step(4'b0001, 0, 1);
    idle(2);
    step(4'b1110, 0, 2);   // R2: probe 1 wins, R3: 2 lost
    step(4'b1111, 0, 3);   // R2: probe 0 wins, R3: 3 lost
    step(4'b1000, 0, 4);
    step(4'b0100, 0, 5);
    idle(100);
    step(4'b0010, 0, 6);   // R4: delta saturates at 63
    idle(4);
    step(4'b0001, 0, 7);   // R4: delta 5
    check_status("R3 R5");

    // R7: host reset disarms, probes then ignored, contents kept
    host_reset();
    step(4'b1111, 0, 8);
    check_status("R7");
    monitor_drain("R1 R2 R4 R7");

    // R9: index register reads back
    wr_reg(1, 1234);
    rd_reg(1, v);
    check(v == EW'(1234), "R9 index", v, EW'(1234));

    // R6: freeze keeps the faulting sample, blocks later ones
    wr_reg(0, 5);
    step(4'b0001, 0, 10);
    step(4'b0010, 1, 11);
    step(4'b1111, 0, 12);
    step(4'b0101, 0, 13);
    check_status("R6");
    monitor_drain("R6");

    // R8: clear with disarm
    wr_reg(0, 6);
    check_status("R8");

    // R5: wrap around the full buffer
    wr_reg(0, 5);
    for (int i = 0; i < DEPTH + 3; i++) step(4'(1 << (i % 4)), 0, 100 + i);
    check_status("R5");
    monitor_drain("R5");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule